// File: doc/BRIEF.md
# Transmit Timestamp Record Queue with Register Slave

The block sits between the logic that gathers transmit timestamps from the ports and a 32-bit register bus. Each time the core raises a write request, the block takes one record and stores it in an internal first-in first-out store. A record holds five fields: a 28-bit rising-edge timestamp, 4 falling-edge sample bits, a 5-bit port number, a 16-bit frame number and a flag that marks the timestamp as possibly wrong. The core side sees full and empty flags for the store.

Software reads one record through three data words. Reading the first data word removes the oldest record from the store. The same read copies the record's other fields into a shadow register, so the second and third data words return the same record later. A status word gives the fill level and the full and empty flags. A small interrupt controller has set, clear, mask and pending words. It drives one level interrupt that is high while the store holds a record and that source is enabled.

The bus side is a two-state machine. In `BUS_IDLE` it waits for cycle and strobe together. When it sees them, it performs the access: it latches the read data, pops the store for a first-data-word read, and updates the mask for an enable or disable write. Then it moves to `BUS_ACK` (transition "accept"). `BUS_ACK` drives the acknowledge for exactly one cycle and always returns to `BUS_IDLE` (transition "retire").

Top module: `tsfifo_regslave`

## Requirements
- R1: A core write request while the store is not full stores one record, and `core_empty` reads 0 from the cycle after that clock edge.
- R2: A bus read of word address 4 (byte 0x10) returns the oldest record: the rising-edge value in bits 27:0 and the falling-edge bits in bits 31:28. Successive reads return the records in the order they were written.
- R3: Word address 5 (byte 0x14) returns the port number in bits 4:0 and the frame number in bits 31:16, with all other bits 0. Word address 6 (byte 0x18) returns the flag in bit 0, with the other bits 0. Both return the record taken by the latest read of word address 4, and reading them leaves the fill level unchanged.
- R4: Word address 7 (byte 0x1C) returns the fill level modulo 256 in bits 7:0, full in bit 16 and empty in bit 17, with all other bits 0.
- R5: A core write request while the store is full is dropped. The fill level stays at the depth, and the stored records and their order are unchanged.
- R6: A read of word address 4 while the store is empty does not pop. It returns the values latched by the last successful pop (all zero after reset), and words 5 and 6 keep those values too.
- R7: Every bus access is acknowledged by `bus_ack` high for exactly one cycle. The acknowledge appears in the cycle after the clock edge that sampled `bus_cyc` and `bus_stb` both high.
- R8: A write with bit 0 set to word address 1 (byte 0x04) sets mask bit 0. A write with bit 0 set to word address 0 (byte 0x00) clears it. A write with bit 0 at 0 leaves the mask unchanged. The mask reads back in bit 0 of word address 2 (byte 0x08).
- R9: `irq` and bit 0 of word address 3 (byte 0x0C) are both equal to (store not empty) AND (mask bit 0).
- R10: Writes to word addresses 2 to 7 change nothing: not the mask, the fill level or the stored records.
- R11: An active-low synchronous reset empties the store, clears the mask and the shadow record, and holds `irq` and `bus_ack` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| core_wr_req | input | 1 | Store the record on the core field inputs |
| core_rise | input | 28 | Rising-edge timestamp |
| core_fall | input | 4 | Falling-edge sample bits |
| core_port | input | 5 | Port number |
| core_frame | input | 16 | Frame number |
| core_bad | input | 1 | Timestamp possibly wrong |
| core_full | output | 1 | Store is full |
| core_empty | output | 1 | Store is empty |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_adr | input | 3 | Word address (byte offset / 4) |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Acknowledge for one cycle |
| irq | output | 1 | Level interrupt: records waiting and enabled |

## Verification
The bench builds the block with a store depth of 8 instead of 256. That puts the full flag, the dropped write at full and a complete drain well within a short run. The scoreboard can then check the order of all eight records, the status word at full (0x10008) and the fact that the dropped record never reappears. The single interrupt source keeps its default of one, so set, clear, mask readback and the pending word all act on bit 0.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    parameter int RISE_W  = 28;
    parameter int FALL_W  = 4;
    parameter int PORT_W  = 5;
    parameter int FRAME_W = 16;
    parameter int BUS_W   = 32;
    parameter int LVL_W   = 8;

    typedef struct packed {
        logic               bad;
        logic [FRAME_W-1:0] frame;
        logic [PORT_W-1:0]  port;
        logic [FALL_W-1:0]  fall;
        logic [RISE_W-1:0]  rise;
    } tsf_rec_t;

    typedef enum logic [2:0] {
        W_IRQ_CLR  = 3'd0,
        W_IRQ_SET  = 3'd1,
        W_IRQ_MASK = 3'd2,
        W_IRQ_PEND = 3'd3,
        W_DATA0    = 3'd4,
        W_DATA1    = 3'd5,
        W_DATA2    = 3'd6,
        W_STATUS   = 3'd7
    } tsf_word_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } tsf_bus_state_e;

endpackage

// File: rtl/tsf_store.sv
module tsf_store
    import tsf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  tsf_rec_t         push_rec,
    input  logic             pop_req,
    output tsf_rec_t         head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    tsf_rec_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> (full && count == $past(count)));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req) |=> empty);

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_store_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full) |=> !empty);

endmodule

// File: rtl/tsf_irq.sv
module tsf_irq #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_bits,
    input  logic [NSRC-1:0] clr_bits,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] pend,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            mask <= (mask | set_bits) & ~clr_bits;
        end
    end

    assign pend = src & mask;
    assign irq  = |pend;

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((mask & $past(set_bits)) == $past(set_bits)));

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((mask & $past(clr_bits)) == '0));

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(mask));

endmodule

// File: rtl/tsf_bus_fsm.sv
module tsf_bus_fsm
    import tsf_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int NSRC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cyc,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [2:0]       bus_adr,
    input  logic [BUS_W-1:0] bus_wdat,
    input  tsf_rec_t         head,
    input  logic             empty,
    input  logic             full,
    input  logic [CNT_W-1:0] count,
    input  logic [NSRC-1:0]  mask,
    input  logic [NSRC-1:0]  pend,
    output logic             pop_req,
    output logic [NSRC-1:0]  set_bits,
    output logic [NSRC-1:0]  clr_bits,
    output logic [BUS_W-1:0] bus_rdat,
    output logic             bus_ack
);

    localparam int PAD1 = BUS_W - FRAME_W - PORT_W;
    localparam int PADS = BUS_W - 18;

    tsf_bus_state_e state;
    tsf_bus_state_e state_nx;
    tsf_rec_t       shadow;
    tsf_rec_t       view0;
    tsf_word_e      word;
    logic           access;
    logic [BUS_W-1:0] rd_nx;
    logic [LVL_W-1:0] lvl;
    logic           unused_wdat;

    assign word        = tsf_word_e'(bus_adr);
    assign access      = (state == BUS_IDLE) && bus_cyc && bus_stb;
    assign view0       = empty ? shadow : head;
    assign lvl         = LVL_W'(count);
    assign unused_wdat = ^bus_wdat;

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: if (bus_cyc && bus_stb) state_nx = BUS_ACK;
            BUS_ACK:  state_nx = BUS_IDLE;
        endcase
    end

    always_comb begin
        pop_req  = access && !bus_we && (word == W_DATA0);
        set_bits = (access && bus_we && word == W_IRQ_SET) ? bus_wdat[NSRC-1:0] : '0;
        clr_bits = (access && bus_we && word == W_IRQ_CLR) ? bus_wdat[NSRC-1:0] : '0;
        rd_nx    = '0;
        unique case (word)
            W_IRQ_CLR:  rd_nx = '0;
            W_IRQ_SET:  rd_nx = '0;
            W_IRQ_MASK: rd_nx = BUS_W'(mask);
            W_IRQ_PEND: rd_nx = BUS_W'(pend);
            W_DATA0:    rd_nx = {view0.fall, view0.rise};
            W_DATA1:    rd_nx = {shadow.frame, {PAD1{1'b0}}, shadow.port};
            W_DATA2:    rd_nx = BUS_W'(shadow.bad);
            W_STATUS:   rd_nx = {{PADS{1'b0}}, empty, full, {(16-LVL_W){1'b0}}, lvl};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BUS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            bus_rdat <= '0;
            shadow   <= '0;
        end else begin
            bus_ack <= access;
            if (access && !bus_we) begin
                bus_rdat <= rd_nx;
            end
            if (pop_req && !empty) begin
                shadow <= head;
            end
        end
    end

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_ack_follows_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_cyc && bus_stb));

    assert_shadow_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_req && !empty) |=> $stable(shadow));

endmodule

// File: rtl/tsfifo_regslave.sv
module tsfifo_regslave
    import tsf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NSRC  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_wr_req,
    input  logic [RISE_W-1:0]  core_rise,
    input  logic [FALL_W-1:0]  core_fall,
    input  logic [PORT_W-1:0]  core_port,
    input  logic [FRAME_W-1:0] core_frame,
    input  logic               core_bad,
    output logic               core_full,
    output logic               core_empty,
    input  logic               bus_cyc,
    input  logic               bus_stb,
    input  logic               bus_we,
    input  logic [2:0]         bus_adr,
    input  logic [BUS_W-1:0]   bus_wdat,
    output logic [BUS_W-1:0]   bus_rdat,
    output logic               bus_ack,
    output logic               irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    tsf_rec_t         push_rec;
    tsf_rec_t         head;
    logic             pop_req;
    logic [CNT_W-1:0] count;
    logic [NSRC-1:0]  set_bits;
    logic [NSRC-1:0]  clr_bits;
    logic [NSRC-1:0]  src;
    logic [NSRC-1:0]  mask;
    logic [NSRC-1:0]  pend;

    assign push_rec = '{bad: core_bad, frame: core_frame, port: core_port,
                        fall: core_fall, rise: core_rise};

    generate
        if (NSRC > 1) begin : g_src_wide
            assign src = {{(NSRC-1){1'b0}}, !core_empty};
        end else begin : g_src_one
            assign src = !core_empty;
        end
    endgenerate

    tsf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (core_wr_req),
        .push_rec (push_rec),
        .pop_req  (pop_req),
        .head     (head),
        .full     (core_full),
        .empty    (core_empty),
        .count    (count)
    );

    tsf_irq #(.NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .src      (src),
        .mask     (mask),
        .pend     (pend),
        .irq      (irq)
    );

    tsf_bus_fsm #(.CNT_W(CNT_W), .NSRC(NSRC)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cyc  (bus_cyc),
        .bus_stb  (bus_stb),
        .bus_we   (bus_we),
        .bus_adr  (bus_adr),
        .bus_wdat (bus_wdat),
        .head     (head),
        .empty    (core_empty),
        .full     (core_full),
        .count    (count),
        .mask     (mask),
        .pend     (pend),
        .pop_req  (pop_req),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .bus_rdat (bus_rdat),
        .bus_ack  (bus_ack)
    );

    assert_irq_follows_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == (!core_empty && mask[0])));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!irq && !bus_ack && core_empty));

endmodule

// File: tb/test_tsfifo_regslave.sv
module test_tsfifo_regslave;
    import tsf_pkg::*;

    localparam int  DEPTH = 8;
    localparam time CLK_PERIOD = 20ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               core_wr_req = 1'b0;
    logic [RISE_W-1:0]  core_rise = '0;
    logic [FALL_W-1:0]  core_fall = '0;
    logic [PORT_W-1:0]  core_port = '0;
    logic [FRAME_W-1:0] core_frame = '0;
    logic               core_bad = 1'b0;
    logic               core_full;
    logic               core_empty;
    logic               bus_cyc = 1'b0;
    logic               bus_stb = 1'b0;
    logic               bus_we = 1'b0;
    logic [2:0]         bus_adr = '0;
    logic [31:0]        bus_wdat = '0;
    logic [31:0]        bus_rdat;
    logic               bus_ack;
    logic               irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    tsf_rec_t exp_q[$];
    tsf_rec_t last_rec;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsfifo_regslave #(.DEPTH(DEPTH)) i_tsfifo_regslave (
        .clk(clk), .rst_n(rst_n), .core_wr_req(core_wr_req),
        .core_rise(core_rise), .core_fall(core_fall), .core_port(core_port),
        .core_frame(core_frame), .core_bad(core_bad), .core_full(core_full),
        .core_empty(core_empty), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_rdat(bus_rdat), .bus_ack(bus_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic tsf_rec_t make_rec(input int i);
        tsf_rec_t r;
        r.rise  = RISE_W'(32'h0ABC_DE00 + i * 32'h0011_1111);
        r.fall  = FALL_W'(i + 3);
        r.port  = PORT_W'(i * 3 + 1);
        r.frame = FRAME_W'(16'hC000 + i * 16'h0101);
        r.bad   = i[0];
        return r;
    endfunction

    task automatic bus_xfer(input logic we, input logic [2:0] adr,
                            input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = adr; bus_wdat = wd;
        @(negedge clk);
        chk("R7 ack after strobe", 32'(bus_ack), 32'd1);
        rd = bus_rdat;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        chk("R7 ack single cycle", 32'(bus_ack), 32'd0);
    endtask

    task automatic bus_wr(input logic [2:0] adr, input logic [31:0] wd);
        logic [31:0] dummy;
        bus_xfer(1'b1, adr, wd, dummy);
    endtask

    task automatic bus_rd(input logic [2:0] adr, output logic [31:0] rd);
        bus_xfer(1'b0, adr, 32'h0, rd);
    endtask

    // driver: presents one record to the core port and records what should be stored
    task automatic push_rec(input tsf_rec_t r, input bit expect_store);
        @(negedge clk);
        core_wr_req = 1'b1;
        core_rise = r.rise; core_fall = r.fall; core_port = r.port;
        core_frame = r.frame; core_bad = r.bad;
        @(negedge clk);
        core_wr_req = 1'b0;
        if (expect_store) exp_q.push_back(r);
    endtask

    // monitor: reads one record over the bus and compares with the queue head
    task automatic pop_check(input string tag);
        logic [31:0] d0, d1, d2;
        tsf_rec_t e;
        bus_rd(3'd4, d0);
        bus_rd(3'd5, d1);
        bus_rd(3'd6, d2);
        if (exp_q.size() == 0) begin
            chk({tag, " R2 scoreboard not empty"}, 32'd0, 32'd1);
        end else begin
            e = exp_q.pop_front();
            last_rec = e;
            chk({tag, " R2 data word 0"}, d0, {e.fall, e.rise});
            chk({tag, " R3 data word 1"}, d1, {e.frame, 11'b0, e.port});
            chk({tag, " R3 data word 2"}, d2, {31'b0, e.bad});
        end
    endtask

    function automatic logic [31:0] stat_word(input int lvl, input bit f, input bit e);
        return {14'b0, e, f, 8'b0, 8'(lvl)};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        last_rec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R11 empty after reset", 32'(core_empty), 32'd1);
        chk("R11 not full after reset", 32'(core_full), 32'd0);
        chk("R11 irq low after reset", 32'(irq), 32'd0);
        chk("R11 ack low after reset", 32'(bus_ack), 32'd0);
        bus_rd(3'd7, rd);
        chk("R4 status after reset", rd, stat_word(0, 1'b0, 1'b1));
        bus_rd(3'd2, rd);
        chk("R11 mask clear after reset", rd, 32'd0);

        // three records
        for (int i = 0; i < 3; i++) push_rec(make_rec(i), 1'b1);
        chk("R1 not empty after store", 32'(core_empty), 32'd0);
        bus_rd(3'd7, rd);
        chk("R4 level three", rd, stat_word(3, 1'b0, 1'b0));
        chk("R9 irq masked", 32'(irq), 32'd0);
        bus_rd(3'd3, rd);
        chk("R9 pending masked", rd, 32'd0);

        // enable interrupt
        bus_wr(3'd1, 32'h1);
        bus_rd(3'd2, rd);
        chk("R8 mask set", rd, 32'd1);
        chk("R9 irq raised", 32'(irq), 32'd1);
        bus_rd(3'd3, rd);
        chk("R9 pending set", rd, 32'd1);

        // first record and side-effect-free reads
        pop_check("first");
        bus_rd(3'd5, rd);
        chk("R3 repeat word 1", rd, {last_rec.frame, 11'b0, last_rec.port});
        bus_rd(3'd7, rd);
        chk("R3 level after word reads", rd, stat_word(2, 1'b0, 1'b0));

        // ignored writes
        for (int a = 2; a < 8; a++) bus_wr(3'(a), 32'hFFFF_FFFF);
        bus_rd(3'd2, rd);
        chk("R10 mask untouched", rd, 32'd1);
        bus_rd(3'd7, rd);
        chk("R10 level untouched", rd, stat_word(2, 1'b0, 1'b0));
        bus_rd(3'd5, rd);
        chk("R10 shadow untouched", rd, {last_rec.frame, 11'b0, last_rec.port});

        // drain
        pop_check("second");
        pop_check("third");
        chk("R9 irq drops when empty", 32'(irq), 32'd0);
        bus_rd(3'd7, rd);
        chk("R4 empty again", rd, stat_word(0, 1'b0, 1'b1));

        // read on empty
        bus_rd(3'd4, rd);
        chk("R6 word 0 on empty", rd, {last_rec.fall, last_rec.rise});
        bus_rd(3'd5, rd);
        chk("R6 word 1 on empty", rd, {last_rec.frame, 11'b0, last_rec.port});
        bus_rd(3'd7, rd);
        chk("R6 no pop on empty", rd, stat_word(0, 1'b0, 1'b1));

        // fill to depth and overflow
        for (int i = 10; i < 10 + DEPTH; i++) push_rec(make_rec(i), 1'b1);
        chk("R5 full flag", 32'(core_full), 32'd1);
        bus_rd(3'd7, rd);
        chk("R4 status at full", rd, stat_word(DEPTH, 1'b1, 1'b0));
        push_rec(make_rec(99), 1'b0);
        bus_rd(3'd7, rd);
        chk("R5 level after dropped write", rd, stat_word(DEPTH, 1'b1, 1'b0));
        for (int i = 0; i < DEPTH; i++) pop_check("drain");
        chk("R5 dropped record absent", 32'(core_empty), 32'd1);
        chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);

        // disable controls
        bus_wr(3'd0, 32'h0);
        bus_rd(3'd2, rd);
        chk("R8 clear with zero ignored", rd, 32'd1);
        bus_wr(3'd0, 32'h1);
        bus_rd(3'd2, rd);
        chk("R8 mask cleared", rd, 32'd0);
        push_rec(make_rec(40), 1'b1);
        chk("R9 irq stays low when disabled", 32'(irq), 32'd0);
        bus_wr(3'd1, 32'h0);
        bus_rd(3'd2, rd);
        chk("R8 set with zero ignored", rd, 32'd0);
        bus_wr(3'd1, 32'h1);
        chk("R9 irq with pending record", 32'(irq), 32'd1);
        pop_check("late");

        // reset in the middle of a run
        push_rec(make_rec(50), 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 irq held low in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 empty after second reset", 32'(core_empty), 32'd1);
        bus_rd(3'd2, rd);
        chk("R11 mask after second reset", rd, 32'd0);
        bus_rd(3'd5, rd);
        chk("R11 shadow after second reset", rd, 32'd0);
        bus_rd(3'd4, rd);
        chk("R6 word 0 zero after reset", rd, 32'd0);

        if (!done) begin
            done = 1'b1;
            finish_run();
        end
    end

endmodule